// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is the digital control for one I/O port of up to eight pins. Software writes a per-pin output data register, a three-bit drive mode for each pin and a per-pin bypass bit that takes the driven value from a hardware output instead of the data register. Each pin turns its mode and its output value into five pad controls: strong-high, strong-low, pull-up, pull-down and input-buffer enable. An optional register stage, selected for the whole port, puts the output value on the clock.

On the input side the pad value passes through either a two-flop synchronizer or a transparent path, selected for the whole port. It is then masked by the input-buffer enable and presented as a readable pin-state value. Rising and falling edges of that value set sticky per-pin status bits, which software clears by writing ones. One port interrupt line reports any latched event whose pin still has an edge selection.

The register interface is a single-cycle write strobe with a combinational read. Register addresses: 0 output data, 1/2/3 mode bit 0/1/2 planes (bit i of each plane is pin i), 4 bypass select, 5 rising-edge enable, 6 falling-edge enable, 7 interrupt status (write one to clear), 8 pin state (read-only), 9 port configuration (bit 0 = transparent input, bit 1 = registered output).

Top module: `gpio_port_top`

## Requirements
- R1: After reset every pad control and input-buffer enable is 0 (mode 000), all registers read 0, the pin state reads 0 for any pad value, and the port interrupt is low.
- R2: For each pin, mode {m2,m1,m0} and driven value d give: 000 nothing, input buffer off; 001 nothing, input buffer on; 010 d=1 pull-up, d=0 strong-low; 011 d=1 strong-high, d=0 pull-down; 100 d=1 nothing, d=0 strong-low; 101 d=1 strong-high, d=0 nothing; 110 d=1 strong-high, d=0 strong-low; 111 d=1 pull-up, d=0 pull-down. The input buffer is on for every mode but 000.
- R3: At most one of strong-high, strong-low, pull-up and pull-down is active on a pin at any time.
- R4: A pin whose bypass bit (address 4) is 1 takes its driven value from hwOut; with bypass 0 it takes the output data register.
- R5: With configuration bit 1 clear the driven value follows its source in the same cycle; with it set, a change of source reaches the pad controls one clock later.
- R6: With configuration bit 0 clear the pin state shows a pad change after two clock edges; with it set the pin state follows the pad at once.
- R7: A pin in mode 000 reads 0 in the pin state and raises no edge.
- R8: A rising edge of a pin's state sets its status bit (address 7) when bit i of address 5 is 1, a falling edge when bit i of address 6 is 1; both bits set select both edges, neither selects none. A set bit stays set until a 1 is written to it.
- R9: No edge is recorded on the clock edge at which address 5 or 6 is written.
- R10: portIrq is high exactly when some status bit is set whose pin has at least one edge enable bit set.
- R11: Addresses 0-6 and 9 read back what was written; a write to address 7 clears only the bits written as 1; at most one register is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | NUM_PINS | Write data, bit i for pin i |
| regRdData | output | NUM_PINS | Combinational read data |
| hwOut | input | NUM_PINS | Hardware output value for bypassed pins |
| padIn | input | NUM_PINS | Raw pad input values |
| padStrongHi | output | NUM_PINS | Strong high drive enables |
| padStrongLo | output | NUM_PINS | Strong low drive enables |
| padPullUp | output | NUM_PINS | Resistive pull-up enables |
| padPullDn | output | NUM_PINS | Resistive pull-down enables |
| padInEn | output | NUM_PINS | Digital input buffer enables |
| portIrq | output | 1 | Port interrupt |

## Verification
Register writes and pad-control changes in the transparent output path are due right after the clock edge that takes the write or at once for hwOut; the registered output adds one edge, so the bench samples 1 ns after the input change and again 1 ns after the following edge. The pin state is due after two edges in synchronized mode and at once in transparent mode, and a status bit is due one edge after the pin state moves (three edges from the pad in synchronized mode). Inputs change on the falling clock edge and every sample is taken 1 ns after an edge, counted from the edge that launches the stimulus, with a check both before and at the due cycle where latency is the point.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA   = 4'd0,
    A_MODE0  = 4'd1,
    A_MODE1  = 4'd2,
    A_MODE2  = 4'd3,
    A_BYPASS = 4'd4,
    A_RISE   = 4'd5,
    A_FALL   = 4'd6,
    A_STATUS = 4'd7,
    A_PIN    = 4'd8,
    A_CFG    = 4'd9
  } reg_addr_e;

  localparam int CFG_W = 2;
  localparam int CFG_IN_TRANSP = 0;
  localparam int CFG_OUT_SYNC  = 1;

  typedef struct packed {
    logic wrData;
    logic wrMode0;
    logic wrMode1;
    logic wrMode2;
    logic wrBypass;
    logic wrRise;
    logic wrFall;
    logic clrStatus;
    logic wrCfg;
  } strobe_t;
endpackage

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       drv,
  output logic       strongHi,
  output logic       strongLo,
  output logic       pullUp,
  output logic       pullDn,
  output logic       inEn
);
  always_comb begin
    strongHi = 1'b0;
    strongLo = 1'b0;
    pullUp   = 1'b0;
    pullDn   = 1'b0;
    inEn     = (mode != 3'b000);
    case (mode)
      3'b010: begin pullUp = drv; strongLo = ~drv; end
      3'b011: begin strongHi = drv; pullDn = ~drv; end
      3'b100: strongLo = ~drv;
      3'b101: strongHi = drv;
      3'b110: begin strongHi = drv; strongLo = ~drv; end
      3'b111: begin pullUp = drv; pullDn = ~drv; end
      default: ;
    endcase
  end

  // R3: the pad never sees two drivers at once
  p_pad_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({strongHi, strongLo, pullUp, pullDn}) <= 1);

  // R7: analog mode leaves the pad fully released
  p_analog_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b000) |-> !(strongHi || strongLo || pullUp || pullDn || inEn));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  output strobe_t             strb,
  output logic [NUM_PINS-1:0] regRdData,
  input  logic [NUM_PINS-1:0] dataQ,
  input  logic [NUM_PINS-1:0] mode0Q,
  input  logic [NUM_PINS-1:0] mode1Q,
  input  logic [NUM_PINS-1:0] mode2Q,
  input  logic [NUM_PINS-1:0] bypassQ,
  input  logic [NUM_PINS-1:0] riseQ,
  input  logic [NUM_PINS-1:0] fallQ,
  input  logic [NUM_PINS-1:0] statusQ,
  input  logic [NUM_PINS-1:0] pinState,
  input  logic [CFG_W-1:0]    cfgQ
);
  localparam int PAD_W = NUM_PINS - CFG_W;

  always_comb begin
    strb           = '0;
    strb.wrData    = regWrEn && (regAddr == A_DATA);
    strb.wrMode0   = regWrEn && (regAddr == A_MODE0);
    strb.wrMode1   = regWrEn && (regAddr == A_MODE1);
    strb.wrMode2   = regWrEn && (regAddr == A_MODE2);
    strb.wrBypass  = regWrEn && (regAddr == A_BYPASS);
    strb.wrRise    = regWrEn && (regAddr == A_RISE);
    strb.wrFall    = regWrEn && (regAddr == A_FALL);
    strb.clrStatus = regWrEn && (regAddr == A_STATUS);
    strb.wrCfg     = regWrEn && (regAddr == A_CFG);
  end

  always_comb begin
    case (regAddr)
      A_DATA:   regRdData = dataQ;
      A_MODE0:  regRdData = mode0Q;
      A_MODE1:  regRdData = mode1Q;
      A_MODE2:  regRdData = mode2Q;
      A_BYPASS: regRdData = bypassQ;
      A_RISE:   regRdData = riseQ;
      A_FALL:   regRdData = fallQ;
      A_STATUS: regRdData = statusQ;
      A_PIN:    regRdData = pinState;
      A_CFG:    regRdData = {{PAD_W{1'b0}}, cfgQ};
      default:  regRdData = '0;
    endcase
  end

  // R11: a single write never lands in two registers
  p_one_target_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb));
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strb,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] hwOut,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padStrongHi,
  output logic [NUM_PINS-1:0] padStrongLo,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] padPullDn,
  output logic [NUM_PINS-1:0] padInEn,
  output logic                portIrq,
  output logic [NUM_PINS-1:0] dataQ,
  output logic [NUM_PINS-1:0] mode0Q,
  output logic [NUM_PINS-1:0] mode1Q,
  output logic [NUM_PINS-1:0] mode2Q,
  output logic [NUM_PINS-1:0] bypassQ,
  output logic [NUM_PINS-1:0] riseQ,
  output logic [NUM_PINS-1:0] fallQ,
  output logic [NUM_PINS-1:0] statusQ,
  output logic [NUM_PINS-1:0] pinState,
  output logic [CFG_W-1:0]    cfgQ
);
  logic [NUM_PINS-1:0] outSel, outSyncQ, outVal;
  logic [NUM_PINS-1:0] syncA, syncB, inSel, prevState;
  logic [NUM_PINS-1:0] riseEvt, fallEvt, pinEvt, clrMask;
  logic                cfgWriteNow;

  // configuration and data registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dataQ   <= '0;
      mode0Q  <= '0;
      mode1Q  <= '0;
      mode2Q  <= '0;
      bypassQ <= '0;
      riseQ   <= '0;
      fallQ   <= '0;
      cfgQ    <= '0;
    end else begin
      if (strb.wrData)   dataQ   <= wrData;
      if (strb.wrMode0)  mode0Q  <= wrData;
      if (strb.wrMode1)  mode1Q  <= wrData;
      if (strb.wrMode2)  mode2Q  <= wrData;
      if (strb.wrBypass) bypassQ <= wrData;
      if (strb.wrRise)   riseQ   <= wrData;
      if (strb.wrFall)   fallQ   <= wrData;
      if (strb.wrCfg)    cfgQ    <= wrData[CFG_W-1:0];
    end
  end

  // output value: source select, then optional register stage
  assign outSel = (bypassQ & hwOut) | (~bypassQ & dataQ);

  always_ff @(posedge clk) begin
    if (rst) outSyncQ <= '0;
    else     outSyncQ <= outSel;
  end

  assign outVal = cfgQ[CFG_OUT_SYNC] ? outSyncQ : outSel;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_decode u_dec (
      .clk      (clk),
      .rst      (rst),
      .mode     ({mode2Q[i], mode1Q[i], mode0Q[i]}),
      .drv      (outVal[i]),
      .strongHi (padStrongHi[i]),
      .strongLo (padStrongLo[i]),
      .pullUp   (padPullUp[i]),
      .pullDn   (padPullDn[i]),
      .inEn     (padInEn[i])
    );
  end

  // input path: two-flop synchronizer or transparent, masked by buffer enable
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign inSel    = cfgQ[CFG_IN_TRANSP] ? padIn : syncB;
  assign pinState = inSel & padInEn;

  // edge detection and sticky status
  assign cfgWriteNow = strb.wrRise | strb.wrFall;
  assign riseEvt     = pinState & ~prevState & riseQ;
  assign fallEvt     = ~pinState & prevState & fallQ;
  assign pinEvt      = (riseEvt | fallEvt) & {NUM_PINS{~cfgWriteNow}};
  assign clrMask     = strb.clrStatus ? wrData : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevState <= '0;
      statusQ   <= '0;
    end else begin
      prevState <= pinState;
      statusQ   <= (statusQ & ~clrMask) | pinEvt;
    end
  end

  assign portIrq = |(statusQ & (riseQ | fallQ));

  // R8: a latched event survives every cycle without a matching clear
  for (genvar k = 0; k < NUM_PINS; k++) begin : g_chk
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      (statusQ[k] && !(strb.clrStatus && wrData[k])) |=> statusQ[k]);
  end

  // R9: an edge-selection write adds no event on its own edge
  p_cfg_write_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (cfgWriteNow && !strb.clrStatus) |=> (statusQ == $past(statusQ)));
endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  input  logic [NUM_PINS-1:0] hwOut,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padStrongHi,
  output logic [NUM_PINS-1:0] padStrongLo,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] padPullDn,
  output logic [NUM_PINS-1:0] padInEn,
  output logic                portIrq
);
  strobe_t             strb;
  logic [NUM_PINS-1:0] dataQ, mode0Q, mode1Q, mode2Q, bypassQ;
  logic [NUM_PINS-1:0] riseQ, fallQ, statusQ, pinState;
  logic [CFG_W-1:0]    cfgQ;

  gpio_port_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .strb      (strb),
    .regRdData (regRdData),
    .dataQ     (dataQ),
    .mode0Q    (mode0Q),
    .mode1Q    (mode1Q),
    .mode2Q    (mode2Q),
    .bypassQ   (bypassQ),
    .riseQ     (riseQ),
    .fallQ     (fallQ),
    .statusQ   (statusQ),
    .pinState  (pinState),
    .cfgQ      (cfgQ)
  );

  gpio_port_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .wrData      (regWrData),
    .hwOut       (hwOut),
    .padIn       (padIn),
    .padStrongHi (padStrongHi),
    .padStrongLo (padStrongLo),
    .padPullUp   (padPullUp),
    .padPullDn   (padPullDn),
    .padInEn     (padInEn),
    .portIrq     (portIrq),
    .dataQ       (dataQ),
    .mode0Q      (mode0Q),
    .mode1Q      (mode1Q),
    .mode2Q      (mode2Q),
    .bypassQ     (bypassQ),
    .riseQ       (riseQ),
    .fallQ       (fallQ),
    .statusQ     (statusQ),
    .pinState    (pinState),
    .cfgQ        (cfgQ)
  );
endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_top_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         regWrEn = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] regRdData;
  logic [N-1:0] hwOut = '0;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] padStrongHi, padStrongLo, padPullUp, padPullDn, padInEn;
  logic         portIrq;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  gpio_port_top #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hwOut(hwOut), .padIn(padIn),
    .padStrongHi(padStrongHi), .padStrongLo(padStrongLo), .padPullUp(padPullUp),
    .padPullDn(padPullDn), .padInEn(padInEn), .portIrq(portIrq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic setModeAll(input logic [2:0] m);
    wr(4'd1, {N{m[0]}});
    wr(4'd2, {N{m[1]}});
    wr(4'd3, {N{m[2]}});
  endtask

  // expected {strongHi, strongLo, pullUp, pullDn, inEn} from the mode table
  function automatic logic [4:0] expPad(input logic [2:0] m, input logic d);
    case (m)
      3'b000: return 5'b00000;
      3'b001: return 5'b00001;
      3'b010: return d ? 5'b00101 : 5'b01001;
      3'b011: return d ? 5'b10001 : 5'b00011;
      3'b100: return d ? 5'b00001 : 5'b01001;
      3'b101: return d ? 5'b10001 : 5'b00001;
      3'b110: return d ? 5'b10001 : 5'b01001;
      default: return d ? 5'b00101 : 5'b00011;
    endcase
  endfunction

  function automatic logic [63:0] padVec();
    return {24'd0, padStrongHi, padStrongLo, padPullUp, padPullDn, padInEn};
  endfunction

  function automatic logic [63:0] rep(input logic [4:0] e);
    return {24'd0, {N{e[4]}}, {N{e[3]}}, {N{e[2]}}, {N{e[1]}}, {N{e[0]}}};
  endfunction

  task automatic t_reset;
    logic [N-1:0] v;
    padIn = '1;
    #1;
    chk("R1 pads after reset", padVec(), 64'd0);
    chk("R1 irq after reset", {63'd0, portIrq}, 64'd0);
    rd(4'd8, v); chk("R1 pin state after reset", {56'd0, v}, 64'd0);
    rd(4'd0, v); chk("R1 data after reset", {56'd0, v}, 64'd0);
    rd(4'd3, v); chk("R1 mode2 after reset", {56'd0, v}, 64'd0);
    rd(4'd7, v); chk("R1 status after reset", {56'd0, v}, 64'd0);
    padIn = '0;
  endtask

  task automatic t_regs;
    logic [N-1:0] v;
    wr(4'd0, 8'hA5); rd(4'd0, v); chk("R11 data readback", {56'd0, v}, 64'hA5);
    wr(4'd4, 8'h3C); rd(4'd4, v); chk("R11 bypass readback", {56'd0, v}, 64'h3C);
    wr(4'd9, 8'hFF); rd(4'd9, v); chk("R11 cfg readback", {56'd0, v}, 64'h3);
    wr(4'd7, 8'hFF); rd(4'd7, v); chk("R11 status W1C on zero", {56'd0, v}, 64'h0);
    wr(4'd9, 8'h00); wr(4'd4, 8'h00); wr(4'd0, 8'h00);
  endtask

  task automatic t_decode;
    for (int m = 0; m < 8; m++) begin
      setModeAll(m[2:0]);
      wr(4'd0, 8'hFF); #1;
      chk($sformatf("R2 mode %0d data 1", m), padVec(), rep(expPad(m[2:0], 1'b1)));
      wr(4'd0, 8'h00); #1;
      chk($sformatf("R2 mode %0d data 0", m), padVec(), rep(expPad(m[2:0], 1'b0)));
    end
    setModeAll(3'b110);
    wr(4'd0, 8'h5A); #1;
    chk("R2 strong mixed high", {56'd0, padStrongHi}, 64'h5A);
    chk("R2 strong mixed low", {56'd0, padStrongLo}, 64'hA5);
    setModeAll(3'b111); #1;
    chk("R3 pull mixed", {48'd0, padPullUp, padPullDn}, 64'h5AA5);
    chk("R3 no strong in pull mode", {48'd0, padStrongHi, padStrongLo}, 64'h0);
  endtask

  task automatic t_bypass;
    setModeAll(3'b110);
    wr(4'd0, 8'h00);
    hwOut = 8'h33;
    wr(4'd4, 8'h0F); #1;
    chk("R4 bypass mix", {56'd0, padStrongHi}, 64'h03);
    wr(4'd0, 8'hFF); #1;
    chk("R4 bypass mix data high", {56'd0, padStrongHi}, 64'hF3);
    wr(4'd4, 8'h00); #1;
    chk("R4 bypass off", {56'd0, padStrongHi}, 64'hFF);
    hwOut = '0;
  endtask

  task automatic t_outsync;
    setModeAll(3'b110);
    wr(4'd4, 8'hFF);
    hwOut = 8'h00;
    wr(4'd9, 8'h02);
    hwOut = 8'hFF; #1;
    chk("R5 registered output holds", {56'd0, padStrongHi}, 64'h00);
    @(posedge clk); #1;
    chk("R5 registered output after edge", {56'd0, padStrongHi}, 64'hFF);
    wr(4'd9, 8'h00);
    @(negedge clk);
    hwOut = 8'h0F; #1;
    chk("R5 transparent output immediate", {56'd0, padStrongHi}, 64'h0F);
    hwOut = '0;
    wr(4'd4, 8'h00);
  endtask

  task automatic t_insync;
    logic [N-1:0] v;
    setModeAll(3'b001);
    wr(4'd9, 8'h00);
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'h81;
    rd(4'd8, v); chk("R6 sync before edges", {56'd0, v}, 64'h00);
    @(posedge clk); rd(4'd8, v); chk("R6 sync after one edge", {56'd0, v}, 64'h00);
    @(posedge clk); rd(4'd8, v); chk("R6 sync after two edges", {56'd0, v}, 64'h81);
    wr(4'd9, 8'h01);
    padIn = 8'h18;
    rd(4'd8, v); chk("R6 transparent immediate", {56'd0, v}, 64'h18);
    wr(4'd1, 8'h0F);
    padIn = 8'hFF;
    rd(4'd8, v); chk("R7 analog pins read zero", {56'd0, v}, 64'h0F);
    padIn = 8'h00;
    wr(4'd1, 8'hFF);
  endtask

  task automatic t_irq;
    logic [N-1:0] v;
    setModeAll(3'b001);
    wr(4'd9, 8'h01);
    padIn = 8'h00;
    wr(4'd5, 8'h05);
    wr(4'd6, 8'h06);
    wr(4'd7, 8'hFF);
    @(negedge clk);
    padIn = 8'h0F;
    @(posedge clk); rd(4'd7, v); chk("R8 rising edges latched", {56'd0, v}, 64'h05);
    chk("R10 irq on latched event", {63'd0, portIrq}, 64'd1);
    @(negedge clk);
    padIn = 8'h00;
    @(posedge clk); rd(4'd7, v); chk("R8 falling edges added", {56'd0, v}, 64'h07);
    repeat (4) @(posedge clk);
    rd(4'd7, v); chk("R8 status sticky", {56'd0, v}, 64'h07);
    wr(4'd7, 8'h01); rd(4'd7, v); chk("R11 W1C single bit", {56'd0, v}, 64'h06);
    wr(4'd5, 8'h00); wr(4'd6, 8'h00); #1;
    chk("R10 irq gated by enables", {63'd0, portIrq}, 64'd0);
    rd(4'd7, v); chk("R10 status kept while gated", {56'd0, v}, 64'h06);
    wr(4'd7, 8'h06); rd(4'd7, v); chk("R8 cleared", {56'd0, v}, 64'h00);
  endtask

  task automatic t_cfgquiet;
    logic [N-1:0] v;
    wr(4'd9, 8'h01);
    wr(4'd5, 8'h01);
    wr(4'd7, 8'hFF);
    padIn = 8'h00;
    @(negedge clk);
    padIn = 8'h01;
    regWrEn = 1'b1; regAddr = 4'd5; regWrData = 8'h01;
    @(negedge clk);
    regWrEn = 1'b0;
    rd(4'd7, v); chk("R9 edge during cfg write ignored", {56'd0, v}, 64'h00);
    chk("R9 irq low", {63'd0, portIrq}, 64'd0);
    @(negedge clk); padIn = 8'h00;
    @(negedge clk); padIn = 8'h01;
    @(posedge clk); rd(4'd7, v); chk("R9 later edge seen", {56'd0, v}, 64'h01);
    wr(4'd7, 8'hFF);
    // synchronized interrupt latency: three edges from pad to status
    wr(4'd9, 8'h00);
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'h01;
    @(posedge clk); @(posedge clk); rd(4'd7, v);
    chk("R6 sync irq not yet", {56'd0, v}, 64'h00);
    @(posedge clk); rd(4'd7, v);
    chk("R6 sync irq after three edges", {56'd0, v}, 64'h01);
    wr(4'd7, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_regs;
    t_decode;
    t_bypass;
    t_outsync;
    t_insync;
    t_irq;
    t_cfgquiet;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule